// File: doc/BRIEF.md
# Video Media Execution Unit

A small execution unit that sits beside a RISC pipeline. When the pipeline pulses `start`, the unit captures an opcode and two 32-bit source words. Two cycles later it returns either a 32-bit result or an update to its internal 64-bit accumulator.

It has three operations:

- **Multiply.** A signed 16x16 multiply of the low halves of the two source words.
- **Clip.** Saturates a signed 32-bit value to the 0..255 pixel range.
- **Dual weighted accumulate.** Used for sub-pixel interpolation. It scales one 16-bit sample by coefficient weight 0 and adds the product into the high accumulator half. In the same operation it scales a second sample by coefficient weight 1 and adds that product into the low half.

The two coefficient weights are 16-bit signed registers, loaded through their own write port. The accumulator can be cleared synchronously.

The unit is fully pipelined and accepts one `start` per cycle. It has no back-pressure: the latency is fixed and the result appears as a single-cycle `res_valid` pulse. The consumer must take it in that cycle.

The 64-bit source that the accumulate reads is `{src_b, src_a}`. Its bits 15:0 are `src_a[15:0]` and its bits 47:32 are `src_b[15:0]`.

Top module: `vmx_exec_unit`

## Requirements
- R1: Opcode 2'b00 (multiply) returns `res_data` = signed(`src_a[15:0]`) x signed(`src_b[15:0]`) as a 32-bit two's-complement value. Bits 31:16 of both sources are ignored.
- R2: Opcode 2'b01 (clip) returns 0 when `src_a`, read as a signed 32-bit value, is negative.
- R3: For clip, a `src_a` above 255 returns 255 (0xFF). A `src_a` in 0..255 is returned unchanged.
- R4: Opcode 2'b10 (accumulate) adds signed(`src_a[15:0]`) x weight 0 into accumulator bits 63:32, wrapping modulo 2^32. Its `res_data` is 0 and `res_illegal` is 0.
- R5: The same accumulate operation adds signed(`src_b[15:0]`) x weight 1 into accumulator bits 31:0, wrapping modulo 2^32 with no carry into the high half.
- R6: A cycle with `coef_we`=1 loads `coef_wdata` into weight 0 (`coef_sel`=0) or weight 1 (`coef_sel`=1). The weight holds its value until it is rewritten. An operation started in the same cycle as a write uses the old weight.
- R7: A `start` sampled at clock edge k gives `res_valid`=1 for exactly one cycle, after edge k+2. The accumulator update takes effect at the same edge. Starts on consecutive cycles each produce their own result.
- R8: `acc_clr` zeroes the accumulator at the next edge. It takes priority over an accumulate update that lands on that same edge.
- R9: Synchronous active-high `rst` zeroes the accumulator, both weights and `res_valid`.
- R10: Opcode 2'b11 is undefined. It returns `res_data`=0 with `res_illegal`=1 and leaves the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation strobe, one operation per cycle |
| opcode | input | 2 | Operation select |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| coef_we | input | 1 | Weight write enable |
| coef_sel | input | 1 | Weight select: 0 = weight 0, 1 = weight 1 |
| coef_wdata | input | 16 | Signed weight value |
| acc_clr | input | 1 | Synchronous accumulator clear |
| res_valid | output | 1 | Single-cycle result strobe |
| res_data | output | 32 | Result word |
| res_illegal | output | 1 | Undefined opcode flag, qualified by `res_valid` |
| acc_out | output | 64 | Current accumulator value |

## Verification
The multiply is driven with nonzero upper bits and with the most negative operands. A design that multiplies unsigned, or that lets bits 31:16 leak in, returns a wrong product.

The clip is checked at -1, at the most negative and most positive inputs, and at 0, 255 and 256. An off-by-one boundary, or an unsigned compare, clips these wrongly.

The accumulate is checked on the following cases:
- **Low-half wrap.** A design whose halves share a carry chain corrupts the high half.
- **Back-to-back starts.** A design with a stale accumulator read-back loses one update.
- **Weight write in the same cycle as a start.** A bypassing design uses the new weight.
- **Clear landing with an update.** A design with the wrong priority leaves a nonzero value.
- **Undefined opcode.** A design that updates the accumulator on opcode 2'b11 changes its value.

// File: rtl/vmx_pkg.sv
package vmx_pkg;
  localparam int DATA_W = 32;
  localparam int HALF_W = 16;
  localparam int PIX_MAX = 255;

  typedef enum logic [1:0] {
    OP_MUL   = 2'b00,
    OP_CLIP  = 2'b01,
    OP_MAC   = 2'b10,
    OP_UNDEF = 2'b11
  } vmx_op_e;
endpackage

// File: rtl/vmx_coef_regs.sv
module vmx_coef_regs #(
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic                 sel,
  input  logic signed [CW-1:0] wdata,
  output logic signed [CW-1:0] w0,
  output logic signed [CW-1:0] w1
);
  always_ff @(posedge clk) begin
    if (rst) begin
      w0 <= '0;
      w1 <= '0;
    end else if (we) begin
      if (sel) w1 <= wdata;
      else     w0 <= wdata;
    end
  end

  // R6: a weight changes only on a write aimed at it
  assert_w0_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(we) && !$past(sel))) |-> $stable(w0));
  assert_w1_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(we) && $past(sel))) |-> $stable(w1));
endmodule

// File: rtl/vmx_issue_stage.sv
module vmx_issue_stage
  import vmx_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int HW = HALF_W,
  localparam int PW = 2 * HW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  vmx_op_e              opcode,
  input  logic [DW-1:0]        src_a,
  input  logic [DW-1:0]        src_b,
  input  logic signed [HW-1:0] w0,
  input  logic signed [HW-1:0] w1,
  output logic                 s1_valid,
  output vmx_op_e              s1_op,
  output logic [DW-1:0]        s1_a,
  output logic signed [PW-1:0] s1_prod [2]
);
  logic signed [HW-1:0] mul_x [2];
  logic signed [HW-1:0] mul_y [2];

  always_comb begin
    mul_x[0] = src_a[HW-1:0];
    mul_y[0] = (opcode == OP_MUL) ? src_b[HW-1:0] : w0;
    mul_x[1] = src_b[HW-1:0];
    mul_y[1] = w1;
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) s1_prod[g] <= '0;
      else if (start) s1_prod[g] <= PW'(mul_x[g] * mul_y[g]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_op    <= OP_MUL;
      s1_a     <= '0;
    end else begin
      s1_valid <= start;
      if (start) begin
        s1_op <= opcode;
        s1_a  <= src_a;
      end
    end
  end
endmodule

// File: rtl/vmx_accum.sv
module vmx_accum #(
  parameter int HW2 = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  upd,
  input  logic signed [HW2-1:0] add_hi,
  input  logic signed [HW2-1:0] add_lo,
  output logic [2*HW2-1:0]      acc
);
  logic [HW2-1:0] hi_q, lo_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (upd) begin
      hi_q <= hi_q + add_hi;
      lo_q <= lo_q + add_lo;
    end
  end

  assign acc = {hi_q, lo_q};

  // R8: a clear leaves zero, whatever update was requested
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (acc == '0));
  // R10: without an update or a clear the accumulator holds
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clr) && !$past(upd)) |-> $stable(acc));
endmodule

// File: rtl/vmx_exec_unit.sv
module vmx_exec_unit
  import vmx_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int HW = HALF_W,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    opcode,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  logic          coef_we,
  input  logic          coef_sel,
  input  logic [HW-1:0] coef_wdata,
  input  logic          acc_clr,
  output logic          res_valid,
  output logic [DW-1:0] res_data,
  output logic          res_illegal,
  output logic [AW-1:0] acc_out
);
  logic signed [HW-1:0]   w0, w1;
  logic                   s1_valid;
  vmx_op_e                s1_op;
  logic [DW-1:0]          s1_a;
  logic signed [2*HW-1:0] s1_prod [2];
  logic [DW-1:0]          res_next;
  logic                   mac_upd;
  vmx_op_e                op_q2;

  vmx_coef_regs #(.CW(HW)) coef_i (
    .clk(clk), .rst(rst), .we(coef_we), .sel(coef_sel),
    .wdata(coef_wdata), .w0(w0), .w1(w1));

  vmx_issue_stage #(.DW(DW), .HW(HW)) issue_i (
    .clk(clk), .rst(rst), .start(start), .opcode(vmx_op_e'(opcode)),
    .src_a(src_a), .src_b(src_b), .w0(w0), .w1(w1),
    .s1_valid(s1_valid), .s1_op(s1_op), .s1_a(s1_a), .s1_prod(s1_prod));

  assign mac_upd = s1_valid && (s1_op == OP_MAC);

  vmx_accum #(.HW2(DW)) acc_i (
    .clk(clk), .rst(rst), .clr(acc_clr), .upd(mac_upd),
    .add_hi(DW'(s1_prod[0])), .add_lo(DW'(s1_prod[1])), .acc(acc_out));

  always_comb begin
    unique case (s1_op)
      OP_MUL:  res_next = DW'(s1_prod[0]);
      OP_CLIP: begin
        if (s1_a[DW-1])                    res_next = '0;
        else if (s1_a > DW'(PIX_MAX))      res_next = DW'(PIX_MAX);
        else                               res_next = s1_a;
      end
      default: res_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_illegal <= 1'b0;
      op_q2       <= OP_MUL;
    end else begin
      res_valid   <= s1_valid;
      res_data    <= s1_valid ? res_next : '0;
      res_illegal <= s1_valid && (s1_op == OP_UNDEF);
      op_q2       <= s1_op;
    end
  end

  // R7: every start yields a result strobe two edges later
  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    start |-> ##2 res_valid);
  // R3: a clip result never exceeds the pixel range
  assert_clip_range_R3: assert property (@(posedge clk) disable iff (rst)
    (res_valid && op_q2 == OP_CLIP) |-> (res_data <= DW'(PIX_MAX)));
  // R10: the illegal flag comes only with a zero, valid result
  assert_illegal_zero_R10: assert property (@(posedge clk) disable iff (rst)
    res_illegal |-> (res_valid && res_data == '0));
  // R4: an accumulate reports a zero result word and no flag
  assert_mac_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && op_q2 == OP_MAC) |-> (res_data == '0 && !res_illegal));
endmodule

// File: tb/vmx_exec_unit_tb_top.sv
module vmx_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst, start, coef_we, coef_sel, acc_clr;
  logic [1:0]  opcode;
  logic [31:0] src_a, src_b;
  logic [15:0] coef_wdata;
  logic        res_valid, res_illegal;
  logic [31:0] res_data;
  logic [63:0] acc_out;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vmx_exec_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode),
    .src_a(src_a), .src_b(src_b), .coef_we(coef_we), .coef_sel(coef_sel),
    .coef_wdata(coef_wdata), .acc_clr(acc_clr), .res_valid(res_valid),
    .res_data(res_data), .res_illegal(res_illegal), .acc_out(acc_out));

  // {opcode, src_a, src_b, expected data, expected illegal}
  localparam int NV = 13;
  localparam logic [98:0] VEC [NV] = '{
    {2'b00, 32'h0000_0003, 32'h0000_0004, 32'h0000_000C, 1'b0},
    {2'b00, 32'h0000_FFFE, 32'h0000_0003, 32'hFFFF_FFFA, 1'b0},
    {2'b00, 32'hABCD_0002, 32'h1234_0005, 32'h0000_000A, 1'b0},
    {2'b00, 32'h0000_8000, 32'h0000_8000, 32'h4000_0000, 1'b0},
    {2'b00, 32'h0000_7FFF, 32'h0000_8000, 32'hC000_8000, 1'b0},
    {2'b01, 32'hFFFF_FFFF, 32'h0,         32'h0000_0000, 1'b0},
    {2'b01, 32'h8000_0000, 32'h0,         32'h0000_0000, 1'b0},
    {2'b01, 32'h0000_0000, 32'h0,         32'h0000_0000, 1'b0},
    {2'b01, 32'h0000_00FF, 32'h0,         32'h0000_00FF, 1'b0},
    {2'b01, 32'h0000_0100, 32'h0,         32'h0000_00FF, 1'b0},
    {2'b01, 32'h0000_0064, 32'h0,         32'h0000_0064, 1'b0},
    {2'b01, 32'h7FFF_FFFF, 32'h0,         32'h0000_00FF, 1'b0},
    {2'b11, 32'h0000_0005, 32'h0000_0007, 32'h0000_0000, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start = 1'b1; opcode = op; src_a = a; src_b = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic write_coef(input logic sel, input logic [15:0] v);
    @(negedge clk);
    coef_we = 1'b1; coef_sel = sel; coef_wdata = v;
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  initial begin
    rst = 1'b1; start = 0; coef_we = 0; coef_sel = 0; acc_clr = 0;
    opcode = 0; src_a = 0; src_b = 0; coef_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9 reset valid", {63'b0, res_valid}, 64'd0);
    chk("R9 reset acc", acc_out, 64'd0);

    // table of stateless operations: R1 R2 R3 R10
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][98:97], VEC[i][96:65], VEC[i][64:33]);
      chk("R7 no early valid", {63'b0, res_valid}, 64'd0);
      @(negedge clk);
      chk("R7 valid", {63'b0, res_valid}, 64'd1);
      chk("R1/R2/R3 data", {32'b0, res_data}, {32'b0, VEC[i][32:1]});
      chk("R10 flag", {63'b0, res_illegal}, {63'b0, VEC[i][0]});
      @(negedge clk);
      chk("R7 single pulse", {63'b0, res_valid}, 64'd0);
    end
    chk("R10 acc untouched", acc_out, 64'd0);

    // R4 R5 accumulate with weights 3 and -2
    write_coef(1'b0, 16'd3);
    write_coef(1'b1, 16'hFFFE);
    issue(2'b10, 32'hFFFF_0005, 32'h0000_0007);
    @(negedge clk);
    chk("R4 mac result word", {32'b0, res_data}, 64'd0);
    chk("R4 R5 acc", acc_out, {32'd15, 32'hFFFF_FFF2});
    issue(2'b10, 32'h0000_FFFF, 32'h0000_FFF8);
    @(negedge clk);
    chk("R5 low wrap, R4 hi", acc_out, {32'd12, 32'd2});

    // R7 back-to-back accumulates
    @(negedge clk);
    start = 1'b1; opcode = 2'b10; src_a = 32'd1; src_b = 32'd0;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R7 first of pair", {63'b0, res_valid}, 64'd1);
    @(negedge clk);
    chk("R7 second of pair", {63'b0, res_valid}, 64'd1);
    chk("R7 both updates", acc_out, {32'd18, 32'd2});

    // R6 write same cycle as start uses old weight
    @(negedge clk);
    start = 1'b1; opcode = 2'b10; src_a = 32'd1; src_b = 32'd0;
    coef_we = 1'b1; coef_sel = 1'b0; coef_wdata = 16'd10;
    @(negedge clk);
    start = 1'b0; coef_we = 1'b0;
    @(negedge clk);
    chk("R6 old weight used", acc_out, {32'd21, 32'd2});
    issue(2'b10, 32'd1, 32'd0);
    @(negedge clk);
    chk("R6 new weight held", acc_out, {32'd31, 32'd2});

    // R10 undefined opcode leaves accumulator
    issue(2'b11, 32'd1, 32'd1);
    @(negedge clk);
    chk("R10 acc after undefined", acc_out, {32'd31, 32'd2});

    // R8 clear landing with an update
    issue(2'b10, 32'd1, 32'd1);
    acc_clr = 1'b1;
    @(negedge clk);
    acc_clr = 1'b0;
    chk("R8 clear priority", acc_out, 64'd0);

    // R9 reset zeroes weights
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    issue(2'b10, 32'd1, 32'd1);
    @(negedge clk);
    chk("R9 weights cleared", acc_out, 64'd0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule